// File: doc/BRIEF.md
# Edge/Level Interrupt Pending Unit

This block gathers 31 interrupt request lines, numbered 1 to 31, and presents their state to a processor core over a small 16-bit register bus. Each line is built, through a configuration word fixed at elaboration, as either edge-triggered or level-triggered. An edge line latches a rising edge of its synchronized input into a sticky pending bit that software clears by writing a 1. A level line's status simply follows its synchronized input. Both kinds share one status map split over two 16-bit words.

A pair of enable-mask words selects which pending sources may raise the request to the core. Interrupt handlers use these to let only chosen sources nest. The block drives one request line that is high while any enabled source is pending. It also reports the number of the highest-numbered enabled pending source.

Register access takes one cycle. A 3-bit word select and a write strobe choose among six words. Reads are combinational and writes take effect at the next clock edge. The two clear words are write-only and sit at adjacent word slots, 2 bytes apart.

Top module: `irq_pend_unit`

## Requirements
- R1: After reset every edge pending bit and every enable bit is 0, `irq_req` is 0 and `irq_num` is 0.
- R2: Source n in 1..15 is bit n of the low status word (select 0). Source n in 16..31 is bit n-16 of the high status word (select 1).
- R3: A rising edge on an edge-configured source sets its status bit within 4 clock cycles. The bit stays set after the input falls, until software clears it.
- R4: Writing to clear word select 4 (sources 1..15) or select 5 (sources 16..31) clears every edge pending bit whose data bit is 1. Data bits that are 0 leave their pending bits unchanged.
- R5: When a new rising edge and a clear of the same edge source land in the same cycle, the pending bit stays set.
- R6: A level-configured source's status bit equals its input delayed by the 2-stage synchronizer. Clear-word writes have no effect on it.
- R7: Reading either clear word (select 4 or 5) returns 0xFFFF.
- R8: Bit 0 of the low status word and bit 0 of the low enable word have no source. They always read 0, and writes to them are ignored.
- R9: The enable words (select 2 for sources 1..15, select 3 for sources 16..31) are read/write with the same bit layout as the status words.
- R10: `irq_req` is 1 exactly when some source has both its status bit and its enable bit set.
- R11: `irq_num` gives the highest source number whose status and enable bits are both set, and is 0 when there is none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 31 | Interrupt request lines; bit n is source n (1..31), asynchronous |
| reg_sel | input | 3 | Word select: 0/1 status, 2/3 enable, 4/5 clear |
| reg_wr | input | 1 | Write strobe, sampled at the clock edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for the selected word |
| irq_req | output | 1 | Request to the core: any enabled pending source |
| irq_num | output | 5 | Highest-numbered enabled pending source, 0 if none |

## Verification
Several properties are checked on every cycle. An edge pending bit is sticky unless cleared. A clear without a coincident edge drops the bit. A coincident edge beats the clear. The clear words read as all ones, and the reserved bit reads 0. Whenever a request is raised, `irq_num` names a source that is enabled and pending, and it is 0 when no request is raised. Several behaviours are shown only by the bench's scenarios: the bit mapping of each source number, level sources ignoring clears while tracking their inputs, enable read-back, and the priority choice among many active sources. The bench drives random input and mask patterns against a bench-side model.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
   typedef enum logic [2:0] {
      SEL_STAT_LO = 3'd0,
      SEL_STAT_HI = 3'd1,
      SEL_EN_LO   = 3'd2,
      SEL_EN_HI   = 3'd3,
      SEL_CLR_LO  = 3'd4,
      SEL_CLR_HI  = 3'd5
   } reg_sel_e;

   localparam int unsigned SEL_W = 3;
endpackage

// File: rtl/irqp_sync.sv
module irqp_sync #(
   parameter int unsigned WIDTH  = 31,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("irqp_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("irqp_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= d;
         for (int s = 1; s < int'(STAGES); s++) begin
            chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/irqp_pend.sv
module irqp_pend #(
   parameter int unsigned NUM_SRC   = 31,
   parameter int unsigned MAP_W     = 32,
   parameter logic [MAP_W-1:0] EDGE_MASK = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC:1]   lvl,
   input  logic [NUM_SRC:1]   clr,
   output logic [MAP_W-1:0]   status
);
   generate
      if (NUM_SRC + 1 > MAP_W) begin : g_bad_map
         $error("irqp_pend: NUM_SRC does not fit in MAP_W");
      end
      if (EDGE_MASK[0] !== 1'b0) begin : g_bad_rsvd
         $error("irqp_pend: bit 0 of EDGE_MASK is reserved");
      end
   endgenerate

   assign status[0] = 1'b0;

   genvar i;
   generate
      for (i = 1; i < int'(MAP_W); i++) begin : g_bit
         if (i > int'(NUM_SRC)) begin : g_empty
            assign status[i] = 1'b0;
         end else if (EDGE_MASK[i]) begin : g_edge
            logic prev_q;
            logic pend_q;
            logic rise;

            assign rise = lvl[i] & ~prev_q;

            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  prev_q <= 1'b0;
                  pend_q <= 1'b0;
               end else begin
                  prev_q <= lvl[i];
                  if (rise) begin
                     pend_q <= 1'b1;
                  end else if (clr[i]) begin
                     pend_q <= 1'b0;
                  end
               end
            end

            assign status[i] = pend_q;

            AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
               (pend_q && !clr[i]) |=> pend_q); // R3
            AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
               (pend_q && clr[i] && !(lvl[i] && !prev_q)) |=> !pend_q); // R4
            AST_EDGE_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
               (lvl[i] && !prev_q && clr[i]) |=> pend_q); // R5
         end else begin : g_level
            assign status[i] = lvl[i];
         end
      end
   endgenerate
endmodule

// File: rtl/irqp_regs.sv
module irqp_regs
   import irqp_pkg::*;
#(
   parameter int unsigned NUM_SRC = 31,
   parameter int unsigned WORD_W  = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [SEL_W-1:0]      reg_sel,
   input  logic                  reg_wr,
   input  logic [WORD_W-1:0]     reg_wdata,
   input  logic [2*WORD_W-1:0]   status,
   output logic [WORD_W-1:0]     reg_rdata,
   output logic [2*WORD_W-1:0]   enable,
   output logic [NUM_SRC:1]      clr
);
   localparam int unsigned MAP_W  = 2 * WORD_W;
   localparam int unsigned NWORDS = 2;

   function automatic logic [MAP_W-1:0] valid_bits();
      logic [MAP_W-1:0] v;
      v = '0;
      for (int b = 1; b <= int'(NUM_SRC); b++) begin
         v[b] = 1'b1;
      end
      return v;
   endfunction

   localparam logic [MAP_W-1:0] VALID = valid_bits();

   generate
      if (NUM_SRC + 1 > MAP_W) begin : g_bad_map
         $error("irqp_regs: NUM_SRC does not fit in two words");
      end
   endgenerate

   logic [NWORDS-1:0] en_hit;
   logic [NWORDS-1:0] clr_hit;
   logic [MAP_W-1:0]  en_q;

   assign en_hit[0]  = reg_wr && (reg_sel == SEL_EN_LO);
   assign en_hit[1]  = reg_wr && (reg_sel == SEL_EN_HI);
   assign clr_hit[0] = reg_wr && (reg_sel == SEL_CLR_LO);
   assign clr_hit[1] = reg_wr && (reg_sel == SEL_CLR_HI);

   genvar w;
   generate
      for (w = 0; w < int'(NWORDS); w++) begin : g_enw
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               en_q[w*WORD_W +: WORD_W] <= '0;
            end else if (en_hit[w]) begin
               en_q[w*WORD_W +: WORD_W] <= reg_wdata & VALID[w*WORD_W +: WORD_W];
            end
         end
      end
   endgenerate

   assign enable = en_q;

   genvar i;
   generate
      for (i = 1; i <= int'(NUM_SRC); i++) begin : g_clr
         assign clr[i] = clr_hit[i / WORD_W] & reg_wdata[i % WORD_W];
      end
   endgenerate

   always_comb begin
      unique case (reg_sel)
         SEL_STAT_LO: reg_rdata = status[0 +: WORD_W] & VALID[0 +: WORD_W];
         SEL_STAT_HI: reg_rdata = status[WORD_W +: WORD_W] & VALID[WORD_W +: WORD_W];
         SEL_EN_LO:   reg_rdata = en_q[0 +: WORD_W];
         SEL_EN_HI:   reg_rdata = en_q[WORD_W +: WORD_W];
         SEL_CLR_LO,
         SEL_CLR_HI:  reg_rdata = '1;
         default:     reg_rdata = '0;
      endcase
   end

   AST_CLR_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel == SEL_CLR_LO || reg_sel == SEL_CLR_HI) |-> (reg_rdata == {WORD_W{1'b1}})); // R7
   AST_RSVD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel == SEL_STAT_LO || reg_sel == SEL_EN_LO) |-> (reg_rdata[0] == 1'b0)); // R8
   AST_EN_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (en_hit[1]) |=> (enable[MAP_W-1 -: WORD_W] == ($past(reg_wdata) & VALID[MAP_W-1 -: WORD_W]))); // R9
endmodule

// File: rtl/irqp_prio.sv
module irqp_prio #(
   parameter int unsigned MAP_W = 32,
   parameter int unsigned NUM_W = $clog2(MAP_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [MAP_W-1:0] active,
   output logic             any,
   output logic [NUM_W-1:0] num
);
   generate
      if ((1 << NUM_W) < MAP_W) begin : g_bad_numw
         $error("irqp_prio: NUM_W too narrow for MAP_W");
      end
   endgenerate

   always_comb begin
      num = '0;
      for (int b = 0; b < int'(MAP_W); b++) begin
         if (active[b]) begin
            num = NUM_W'(b);
         end
      end
   end

   assign any = |active;

   AST_NUM_IS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> active[num]); // R11
endmodule

// File: rtl/irq_pend_unit.sv
module irq_pend_unit
   import irqp_pkg::*;
#(
   parameter int unsigned NUM_SRC     = 31,
   parameter int unsigned WORD_W      = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [2*WORD_W-1:0] EDGE_MASK = 32'hA5C3_3C5A,
   parameter int unsigned NUM_W       = $clog2(2*WORD_W)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SRC:1]     src_in,
   input  logic [SEL_W-1:0]     reg_sel,
   input  logic                 reg_wr,
   input  logic [WORD_W-1:0]    reg_wdata,
   output logic [WORD_W-1:0]    reg_rdata,
   output logic                 irq_req,
   output logic [NUM_W-1:0]     irq_num
);
   localparam int unsigned MAP_W = 2 * WORD_W;

   logic [NUM_SRC:1]  src_sync;
   logic [NUM_SRC:1]  clr;
   logic [MAP_W-1:0]  status;
   logic [MAP_W-1:0]  enable;
   logic [MAP_W-1:0]  active;

   irqp_sync #(
      .WIDTH  (NUM_SRC),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (src_in),
      .q     (src_sync)
   );

   irqp_pend #(
      .NUM_SRC   (NUM_SRC),
      .MAP_W     (MAP_W),
      .EDGE_MASK (EDGE_MASK)
   ) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl    (src_sync),
      .clr    (clr),
      .status (status)
   );

   irqp_regs #(
      .NUM_SRC (NUM_SRC),
      .WORD_W  (WORD_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_sel   (reg_sel),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .status    (status),
      .reg_rdata (reg_rdata),
      .enable    (enable),
      .clr       (clr)
   );

   assign active = status & enable;

   irqp_prio #(
      .MAP_W (MAP_W),
      .NUM_W (NUM_W)
   ) u_prio (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (active),
      .any    (irq_req),
      .num    (irq_num)
   );

   AST_REQ_HAS_NUM: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_num != '0)); // R11
   AST_IDLE_NUM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_req |-> (irq_num == '0)); // R10
endmodule

// File: tb/sim_irq_pend_unit.sv
module sim_irq_pend_unit;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] EDGES = 32'hA5C3_3C5A;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:1] src_in = '0;
   logic [2:0]  reg_sel = 3'd0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        irq_req;
   logic [4:0]  irq_num;

   int checks = 0;
   int failures = 0;

   logic [31:0] exp_pend = '0;
   logic [31:0] exp_en = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_pend_unit #(.EDGE_MASK(EDGES)) u0 (
      .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_sel(reg_sel),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_req(irq_req), .irq_num(irq_num)
   );

   function automatic logic [31:0] exp_status();
      logic [31:0] lvl;
      lvl = {src_in, 1'b0} & ~EDGES;
      return (exp_pend & EDGES) | lvl;
   endfunction

   function automatic logic [4:0] exp_top(input logic [31:0] a);
      for (int b = 31; b >= 1; b--) begin
         if (a[b]) return 5'(b);
      end
      return 5'd0;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [2:0] sel, input logic [15:0] exp, input string tag);
      @(negedge clk);
      reg_sel = sel;
      #1;
      check(tag, {16'h0, reg_rdata}, {16'h0, exp});
   endtask

   task automatic wr(input logic [2:0] sel, input logic [15:0] data);
      @(negedge clk);
      reg_sel = sel;
      reg_wdata = data;
      reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic wait_cyc(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic apply_src(input logic [31:1] v);
      @(negedge clk);
      exp_pend = exp_pend | ({v, 1'b0} & ~{src_in, 1'b0} & EDGES);
      src_in = v;
      wait_cyc(4);
   endtask

   task automatic do_clear(input logic [2:0] sel, input logic [15:0] data);
      logic [31:0] m;
      m = (sel == 3'd4) ? {16'h0, data} : {data, 16'h0};
      wr(sel, data);
      exp_pend = exp_pend & ~(m & EDGES);
   endtask

   task automatic do_enable(input logic [2:0] sel, input logic [15:0] data);
      wr(sel, data);
      if (sel == 3'd2) exp_en[15:0] = data & 16'hFFFE;
      else exp_en[31:16] = data;
   endtask

   task automatic check_all(input string tag);
      logic [31:0] st;
      st = exp_status();
      rd(3'd0, st[15:0], {tag, " R2 stat_lo"});
      rd(3'd1, st[31:16], {tag, " R2 stat_hi"});
      rd(3'd2, exp_en[15:0], {tag, " R9 en_lo"});
      rd(3'd3, exp_en[31:16], {tag, " R9 en_hi"});
      check({tag, " R10 irq_req"}, {31'h0, irq_req}, {31'h0, |(st & exp_en)});
      check({tag, " R11 irq_num"}, {27'h0, irq_num}, {27'h0, exp_top(st & exp_en)});
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      wait_cyc(3);
      #1;
      check("R1 irq_req in reset", {31'h0, irq_req}, 32'h0);
      check("R1 irq_num in reset", {27'h0, irq_num}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      wait_cyc(2);
      rd(3'd0, 16'h0, "R1 stat_lo after reset");
      rd(3'd1, 16'h0, "R1 stat_hi after reset");
      rd(3'd2, 16'h0, "R1 en_lo after reset");
      rd(3'd3, 16'h0, "R1 en_hi after reset");
      rd(3'd4, 16'hFFFF, "R7 clr_lo reads ones");
      rd(3'd5, 16'hFFFF, "R7 clr_hi reads ones");

      // R8: reserved bit 0 ignores writes
      do_enable(3'd2, 16'hFFFF);
      rd(3'd2, 16'hFFFE, "R8 en_lo bit0 stays 0");
      do_enable(3'd2, 16'h0000);

      // R3: source 1 is edge, pulse then drop
      apply_src(31'h1);
      apply_src(31'h0);
      rd(3'd0, 16'h0002, "R3 src1 sticky after input fell");
      // R4: zero bits do not clear
      do_clear(3'd4, 16'hFFFD);
      rd(3'd0, 16'h0002, "R4 zero bit leaves src1 pending");
      do_clear(3'd4, 16'h0002);
      rd(3'd0, 16'h0000, "R4 src1 cleared");

      // R6: source 2 is level, clear has no effect
      apply_src(31'h2);
      rd(3'd0, 16'h0004, "R6 level src2 follows input");
      do_clear(3'd4, 16'h0004);
      rd(3'd0, 16'h0004, "R6 level src2 ignores clear");
      apply_src(31'h0);
      rd(3'd0, 16'h0000, "R6 level src2 drops");

      // R5: edge and clear in the same cycle, src1
      apply_src(31'h1);
      apply_src(31'h0);
      @(negedge clk);
      src_in = 31'h1;
      @(negedge clk);
      @(negedge clk);
      reg_sel = 3'd4;
      reg_wdata = 16'h0002;
      reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      wait_cyc(2);
      rd(3'd0, 16'h0002, "R5 new edge beats clear");
      src_in = 31'h0;
      wait_cyc(4);
      do_clear(3'd4, 16'h0002);
      exp_pend = '0;
      rd(3'd0, 16'h0000, "R5 later clear works");

      // R10/R11 directed: enable all, several active
      do_enable(3'd2, 16'hFFFF);
      do_enable(3'd3, 16'hFFFF);
      apply_src(31'h4000_0003);
      check_all("dir1");
      do_enable(3'd3, 16'h0000);
      check_all("dir2 R11 high masked");
      do_clear(3'd4, 16'hFFFF);
      do_clear(3'd5, 16'hFFFF);
      apply_src(31'h0);
      do_clear(3'd4, 16'hFFFF);
      do_clear(3'd5, 16'hFFFF);
      check_all("dir3");

      for (int it = 0; it < 250; it++) begin
         apply_src(31'($urandom));
         if ($urandom_range(0, 1) == 1) do_enable(3'($urandom_range(2, 3)), 16'($urandom));
         if ($urandom_range(0, 1) == 1) do_clear(3'($urandom_range(4, 5)), 16'($urandom));
         check_all("rand");
         if ((it % 25) == 0) rd(3'($urandom_range(4, 5)), 16'hFFFF, "rand R7 clr reads ones");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule